// File: doc/BRIEF.md
# Serial Word Transmitter with Subframe Encoder

This block takes 32-bit words through a valid/ready input and sends each one on a single serial output pin. A one-cycle pulse on `bit_en` sets the pace: every unit the line sends is produced on one such pulse. A 3-bit mode input picks how a word leaves the pin. In the digital-audio subframe mode, each word becomes one 32-slot subframe. The block inserts the preamble, computes the parity slot, and applies bi-phase mark coding, so one subframe takes 64 half-cell pulses. In the two raw modes, the word is sent unchanged, one bit per pulse, either least significant bit first or most significant bit first.

The input word carries four bytes in arrival order. A byte-order input chooses whether those bytes are assembled little-endian or big-endian before the word is sent. The `tx_enable` input starts transmission. When `tx_enable` falls, the word in flight still finishes before the block goes idle. The `idle` output reports when no word is being sent.

Back-pressure: a word moves only in a cycle where both `word_valid` and `word_ready` are high. Between words, `word_ready` rises only in the cycle that carries the final pulse of the current word. If no word is offered in that cycle, the block goes idle and holds the line level.

Top module: `serial_word_tx`

## Requirements
- R1: With mode 3'b000, each accepted word becomes 64 half-cells. For slots 4 to 30, the slot carries ordered-word bit s. Each slot toggles the line at its start and toggles it again at mid-slot when its bit is 1.
- R2: Half-cells 0 to 7 carry a preamble, sent first half-cell first. When the line was low before the subframe, the patterns are B = 11101000, M = 11100010 and W = 11100100. When the line was high, the pattern is inverted.
- R3: Slot 31 carries a parity bit that makes the number of ones over slots 4 to 31 even. This slot is coded like any other data slot.
- R4: Subframes alternate left and right, starting with left. A frame counter runs from 0 to 191 and advances after each right subframe. A left subframe in frame 0 uses B, any other left subframe uses M, and every right subframe uses W.
- R5: With mode 3'b010, the ordered word is sent uncoded, one bit per pulse, bit 0 first.
- R6: With mode 3'b011, the ordered word is sent uncoded, one bit per pulse, bit 31 first.
- R7: Any other mode code is never accepted. `word_ready` stays low, `idle` stays high and `sdo` does not change.
- R8: Byte k of `word_data` is the k-th byte received and sits at bits [8k+7:8k]. With `little_endian` = 1, the ordered word equals `word_data`. With `little_endian` = 0, the byte order is reversed.
- R9: While idle, with `tx_enable` high and a valid mode, `word_ready` is high. While sending, `word_ready` is high only in the cycle that carries the word's final pulse. If no word is taken in that cycle, the block goes idle and `sdo` holds its level.
- R10: When `tx_enable` falls in the middle of a word, that word still completes and no further word is accepted. While the block is idle with `tx_enable` low, the frame counter is held at 0 and the next subframe is left.
- R11: After reset, `sdo` = 0 and `idle` = 1, and `word_ready` is 0 while `tx_enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Pulse that advances the line by one unit (a half-cell or a raw bit) |
| tx_enable | input | 1 | Transmission enable |
| mode | input | 3 | 000 subframe mode, 010 raw LSB first, 011 raw MSB first |
| little_endian | input | 1 | Byte assembly order of the input word |
| word_data | input | 32 | Input word, four bytes in arrival order |
| word_valid | input | 1 | Input word is present |
| word_ready | output | 1 | Block takes the word in this cycle |
| sdo | output | 1 | Serial line |
| idle | output | 1 | High when no word is being sent |

## Verification
The bench first sends isolated words in each mode. It uses single-end-bit patterns, which show whether the bit order is reversed, and byte-distinct patterns, which show whether the byte assembly order is swapped. It then drives subframes with all-one and all-zero payloads: these alternate between even and odd data weight, which exposes wrong parity and preamble inversion on a high line. A six-word stream and a 385-subframe stream tell a correct B/M/W sequence and frame wrap apart from a counter that stops or wraps late. Reserved codes and an enable drop in mid-word separate a correct finish-at-boundary behaviour from early cut-off or an extra acceptance.

// File: rtl/swtx_pkg.sv
package swtx_pkg;

  typedef enum logic [1:0] {
    KIND_IEC  = 2'd0,
    KIND_LSB  = 2'd1,
    KIND_MSB  = 2'd2,
    KIND_NONE = 2'd3
  } kind_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } state_t;

  typedef enum logic [1:0] {
    PRE_SEL_B = 2'd0,
    PRE_SEL_M = 2'd1,
    PRE_SEL_W = 2'd2
  } pre_sel_t;

  localparam int PRE_HALVES = 8;
  localparam int PRE_SLOTS  = 4;

  // half-cell patterns for a line that was low, first half-cell in bit 7
  localparam logic [PRE_HALVES-1:0] PAT_B = 8'b1110_1000;
  localparam logic [PRE_HALVES-1:0] PAT_M = 8'b1110_0010;
  localparam logic [PRE_HALVES-1:0] PAT_W = 8'b1110_0100;

  function automatic kind_t decode_mode(input logic [2:0] m);
    case (m)
      3'b000:  return KIND_IEC;
      3'b010:  return KIND_LSB;
      3'b011:  return KIND_MSB;
      default: return KIND_NONE;
    endcase
  endfunction

  function automatic logic [PRE_HALVES-1:0] pre_pattern(input pre_sel_t s);
    case (s)
      PRE_SEL_B: return PAT_B;
      PRE_SEL_M: return PAT_M;
      default:   return PAT_W;
    endcase
  endfunction

endpackage

// File: rtl/swtx_byte_order.sv
module swtx_byte_order #(
  parameter int WORD_W = 32
) (
  input  logic              little_endian,
  input  logic [WORD_W-1:0] raw_word,
  output logic [WORD_W-1:0] ordered_word
);
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] swapped;

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign swapped[8*(NBYTES-1-k) +: 8] = raw_word[8*k +: 8];
  end

  assign ordered_word = little_endian ? raw_word : swapped;
endmodule

// File: rtl/swtx_slot_fmt.sv
module swtx_slot_fmt #(
  parameter int SLOTS = 32
) (
  input  logic [SLOTS-2:swtx_pkg::PRE_SLOTS] payload,
  output logic [SLOTS-1:0]                   slot_vec
);
  import swtx_pkg::*;

  logic parity_bit;

  // even parity over the payload slots plus the parity slot itself
  assign parity_bit = ^payload;

  assign slot_vec = {parity_bit, payload, {PRE_SLOTS{1'b0}}};
endmodule

// File: rtl/swtx_line_coder.sv
module swtx_line_coder #(
  parameter int CNT_W = 6
) (
  input  logic                            is_iec,
  input  logic [CNT_W-1:0]                cnt,
  input  logic                            cur_lvl,
  input  logic                            pre_lvl,
  input  logic [swtx_pkg::PRE_HALVES-1:0] pre_pat,
  input  logic                            data_bit,
  output logic                            nxt_lvl
);
  import swtx_pkg::*;

  logic       base_lvl;
  logic [2:0] pat_idx;

  always_comb begin
    base_lvl = (cnt == '0) ? cur_lvl : pre_lvl;
    pat_idx  = 3'(PRE_HALVES - 1) - cnt[2:0];
    if (!is_iec) begin
      nxt_lvl = data_bit;
    end else if (cnt < CNT_W'(PRE_HALVES)) begin
      nxt_lvl = pre_pat[pat_idx] ^ base_lvl;
    end else if (!cnt[0]) begin
      nxt_lvl = ~cur_lvl;
    end else begin
      nxt_lvl = data_bit ? ~cur_lvl : cur_lvl;
    end
  end
endmodule

// File: rtl/serial_word_tx.sv
module serial_word_tx #(
  parameter int WORD_W           = 32,
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              tx_enable,
  input  logic [2:0]        mode,
  input  logic              little_endian,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              sdo,
  output logic              idle
);
  import swtx_pkg::*;

  localparam int CNT_W = $clog2(2 * WORD_W);
  localparam int FR_W  = $clog2(FRAMES_PER_BLOCK);
  localparam logic [CNT_W-1:0] RAW_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] IEC_LAST = CNT_W'(2 * WORD_W - 1);
  localparam logic [FR_W-1:0]  FR_LAST  = FR_W'(FRAMES_PER_BLOCK - 1);

  state_t            state_q;
  kind_t             kind_q;
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sdo_q;
  logic              pre_lvl_q;
  logic [FR_W-1:0]   frame_q;
  logic              right_q;

  kind_t             kind_in;
  logic              mode_ok;
  logic              is_iec;
  logic              last;
  logic              step;
  logic              fire;
  logic              shift_now;
  logic              out_bit;
  logic              nxt_lvl;
  logic [WORD_W-1:0] ordered;
  logic [WORD_W-1:0] slot_vec;
  logic [WORD_W-1:0] sh_next;
  pre_sel_t          pre_sel;

  assign kind_in = decode_mode(mode);
  assign mode_ok = (kind_in != KIND_NONE);
  assign is_iec  = (kind_q == KIND_IEC);
  assign last    = (cnt_q == (is_iec ? IEC_LAST : RAW_LAST));
  assign step    = (state_q == ST_SEND) && bit_en;

  assign word_ready = tx_enable && mode_ok && ((state_q == ST_IDLE) || (step && last));
  assign fire       = word_ready && word_valid;

  swtx_byte_order #(.WORD_W(WORD_W)) u_order (
    .little_endian (little_endian),
    .raw_word      (word_data),
    .ordered_word  (ordered)
  );

  swtx_slot_fmt #(.SLOTS(WORD_W)) u_fmt (
    .payload  (ordered[WORD_W-2:PRE_SLOTS]),
    .slot_vec (slot_vec)
  );

  assign pre_sel   = right_q ? PRE_SEL_W : ((frame_q == '0) ? PRE_SEL_B : PRE_SEL_M);
  assign out_bit   = (kind_q == KIND_MSB) ? sh_q[WORD_W-1] : sh_q[0];
  assign shift_now = is_iec ? cnt_q[0] : 1'b1;
  assign sh_next   = (kind_q == KIND_MSB) ? {sh_q[WORD_W-2:0], 1'b0} : {1'b0, sh_q[WORD_W-1:1]};

  swtx_line_coder #(.CNT_W(CNT_W)) u_coder (
    .is_iec   (is_iec),
    .cnt      (cnt_q),
    .cur_lvl  (sdo_q),
    .pre_lvl  (pre_lvl_q),
    .pre_pat  (pre_pattern(pre_sel)),
    .data_bit (out_bit),
    .nxt_lvl  (nxt_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      kind_q    <= KIND_NONE;
      sh_q      <= '0;
      cnt_q     <= '0;
      sdo_q     <= 1'b0;
      pre_lvl_q <= 1'b0;
      frame_q   <= '0;
      right_q   <= 1'b0;
    end else begin
      if (step) begin
        sdo_q <= nxt_lvl;
        cnt_q <= cnt_q + 1'b1;
        if (is_iec && (cnt_q == '0)) pre_lvl_q <= sdo_q;
        if (shift_now) sh_q <= sh_next;
        if (last) begin
          if (is_iec) begin
            if (right_q) begin
              right_q <= 1'b0;
              frame_q <= (frame_q == FR_LAST) ? '0 : frame_q + 1'b1;
            end else begin
              right_q <= 1'b1;
            end
          end
          state_q <= ST_IDLE;
        end
      end
      if ((state_q == ST_IDLE) && !tx_enable) begin
        frame_q <= '0;
        right_q <= 1'b0;
      end
      if (fire) begin
        state_q <= ST_SEND;
        kind_q  <= kind_in;
        cnt_q   <= '0;
        sh_q    <= (kind_in == KIND_IEC) ? slot_vec : ordered;
      end
    end
  end

  assign sdo  = sdo_q;
  assign idle = (state_q == ST_IDLE);

  // even slot parity leaves the line where the preamble started
  assert_even_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_iec && last) |=> (sdo_q == pre_lvl_q));

  assert_line_moves_on_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(sdo));

  assert_idle_holds_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(sdo));

  assert_reserved_stays_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !mode_ok) |=> idle);

  assert_disabled_stays_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !tx_enable) |=> idle);

  assert_frame_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q <= FR_LAST);
endmodule

// File: tb/tb_serial_word_tx.sv
`timescale 1ns/1ps
module tb_serial_word_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        tx_enable = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic        little_endian = 1'b1;
  logic [31:0] word_data = '0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic        sdo;
  logic        idle;

  int checks = 0;
  int failures = 0;

  logic        m_lvl = 1'b0;
  int          m_frame = 0;
  logic        m_right = 1'b0;
  logic [31:0] wbuf [0:399];

  always #2.5 clk = ~clk;

  serial_word_tx dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_enable(tx_enable),
    .mode(mode), .little_endian(little_endian), .word_data(word_data),
    .word_valid(word_valid), .word_ready(word_ready), .sdo(sdo), .idle(idle)
  );

  // {mode, little_endian, word_data, expected ordered word}
  localparam logic [67:0] VEC [0:7] = '{
    {3'b000, 1'b1, 32'h0ABC_DEF0, 32'h0ABC_DEF0},
    {3'b010, 1'b1, 32'h8000_0001, 32'h8000_0001},
    {3'b011, 1'b1, 32'h8000_0003, 32'h8000_0003},
    {3'b010, 1'b0, 32'h1122_3344, 32'h4433_2211},
    {3'b011, 1'b0, 32'hA5C3_0F96, 32'h960F_C3A5},
    {3'b000, 1'b0, 32'h6745_2371, 32'h7123_4567},
    {3'b000, 1'b1, 32'h7FFF_FFF0, 32'h7FFF_FFF0},
    {3'b000, 1'b1, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] swap_bytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [63:0] sub_model(input logic [31:0] w, input logic lvl,
                                            input int frame, input logic right);
    logic [63:0] v;
    logic [7:0]  pat;
    logic        cur;
    logic        b;
    v = '0;
    pat = right ? 8'b1110_0100 : ((frame == 0) ? 8'b1110_1000 : 8'b1110_0010);
    for (int h = 0; h < 8; h++) v[h] = pat[7-h] ^ lvl;
    cur = v[7];
    for (int s = 4; s < 32; s++) begin
      b = (s == 31) ? ^w[30:4] : w[s];
      cur = ~cur;
      v[2*s] = cur;
      if (b) cur = ~cur;
      v[2*s+1] = cur;
    end
    return v;
  endfunction

  task automatic pulse(output logic s);
    @(negedge clk); bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    s = sdo;
  endtask

  task automatic setup_next(input int k, input int n);
    if (k < n) begin
      word_data = wbuf[k];
      word_valid = 1'b1;
    end else begin
      word_valid = 1'b0;
    end
  endtask

  task automatic model_step(input logic [63:0] got, input logic [31:0] ow,
                            input logic [2:0] md, input string pre_tag, input string raw_tag);
    logic [63:0] exp;
    if (md == 3'b000) begin
      exp = sub_model(ow, m_lvl, m_frame, m_right);
      chk(pre_tag, {56'd0, got[7:0]}, {56'd0, exp[7:0]});
      chk("R1", {10'd0, got[61:8]}, {10'd0, exp[61:8]});
      chk("R3", {62'd0, got[63:62]}, {62'd0, exp[63:62]});
      m_lvl = exp[63];
      if (m_right) begin
        m_right = 1'b0;
        m_frame = (m_frame == 191) ? 0 : m_frame + 1;
      end else begin
        m_right = 1'b1;
      end
    end else begin
      exp = '0;
      for (int p = 0; p < 32; p++) exp[p] = (md == 3'b010) ? ow[p] : ow[31-p];
      chk(raw_tag, got, exp);
      m_lvl = exp[31];
    end
  endtask

  task automatic run_stream(input logic [2:0] md, input logic le, input int n,
                            input string pre_tag, input string raw_tag);
    int units;
    logic s;
    logic [63:0] got;
    units = (md == 3'b000) ? 64 : 32;
    @(negedge clk);
    tx_enable = 1'b1; mode = md; little_endian = le;
    word_data = wbuf[0]; word_valid = 1'b1;
    #0.5;
    chk("R9", {63'd0, word_ready}, 64'd1);
    @(negedge clk);
    setup_next(1, n);
    for (int i = 0; i < n; i++) begin
      got = '0;
      for (int p = 0; p < units; p++) begin
        pulse(s);
        got[p] = s;
      end
      setup_next(i + 2, n);
      model_step(got, le ? wbuf[i] : swap_bytes(wbuf[i]), md, pre_tag, raw_tag);
    end
    chk("R9", {63'd0, idle}, 64'd1);
  endtask

  task automatic go_off();
    @(negedge clk);
    tx_enable = 1'b0; word_valid = 1'b0;
    @(negedge clk);
    m_frame = 0; m_right = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic s;
    logic s0;
    logic [63:0] got;
    string tag;

    repeat (3) @(negedge clk);
    chk("R11", {61'd0, sdo, idle, word_ready}, {61'd0, 1'b0, 1'b1, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", {61'd0, sdo, idle, word_ready}, {61'd0, 1'b0, 1'b1, 1'b0});

    // table walk: one word per entry, transmission disabled between entries
    for (int e = 0; e < 8; e++) begin
      wbuf[0] = VEC[e][63:32];
      if (VEC[e][67:65] == 3'b000) tag = "R2";
      else if (!VEC[e][64]) tag = "R8";
      else if (VEC[e][67:65] == 3'b010) tag = "R5";
      else tag = "R6";
      run_stream(VEC[e][67:65], VEC[e][64], 1, "R2", tag);
      // table's expected ordered word against bench byte model (R8)
      chk("R8", {32'd0, (VEC[e][64] ? VEC[e][63:32] : swap_bytes(VEC[e][63:32]))},
          {32'd0, VEC[e][31:0]});
      go_off();
    end

    // reserved codes: never taken, line unchanged (R7)
    for (int r = 0; r < 3; r++) begin
      @(negedge clk);
      tx_enable = 1'b1;
      mode = (r == 0) ? 3'b001 : ((r == 1) ? 3'b111 : 3'b100);
      word_data = 32'hFFFF_FFFF; word_valid = 1'b1;
      #0.5;
      chk("R7", {63'd0, word_ready}, 64'd0);
      s0 = sdo;
      for (int p = 0; p < 4; p++) pulse(s);
      chk("R7", {62'd0, idle, sdo}, {62'd0, 1'b1, s0});
      go_off();
    end

    // continuous stream: B W M W M W (R4)
    for (int i = 0; i < 6; i++) wbuf[i] = 32'h1357_9BD0 ^ (i * 32'h0102_0304);
    run_stream(3'b000, 1'b1, 6, "R4", "R1");
    go_off();

    // enable drop mid-word: word completes, next word not taken (R10)
    wbuf[0] = 32'h5A5A_A5A0;
    @(negedge clk);
    tx_enable = 1'b1; mode = 3'b000; little_endian = 1'b1;
    word_data = wbuf[0]; word_valid = 1'b1;
    @(negedge clk);
    word_data = 32'h0F0F_0F00;
    got = '0;
    for (int p = 0; p < 64; p++) begin
      pulse(s);
      got[p] = s;
      if (p == 9) tx_enable = 1'b0;
    end
    model_step(got, wbuf[0], 3'b000, "R10", "R10");
    chk("R10", {62'd0, idle, word_ready}, {62'd0, 1'b1, 1'b0});
    s0 = sdo;
    for (int p = 0; p < 3; p++) pulse(s);
    chk("R10", {63'd0, sdo}, {63'd0, s0});
    go_off();
    // counters cleared: first subframe after re-enable must carry B (R10)
    wbuf[0] = 32'h0000_0010;
    run_stream(3'b000, 1'b1, 1, "R10", "R1");
    go_off();

    // frame wrap: subframe 384 is a left subframe of frame 0 again (R4)
    for (int i = 0; i < 385; i++) wbuf[i] = (i * 32'h9E37_79B9) & 32'h7FFF_FFF0;
    run_stream(3'b000, 1'b1, 385, "R4", "R1");
    go_off();

    finish_run();
  end
endmodule